// File: doc/BRIEF.md
# Ramped Digital Volume with Soft Mute

This block scales a stream of 24-bit signed stereo samples by a per-channel volume level, once for each sample strobe. Each channel's level is an 8-bit code: 255 passes the sample at unity gain, every code below it removes another half decibel, code 1 sits 127 dB down and code 0 silences the channel. The block never jumps to a new level. It keeps a running level for each channel and walks it one code at a time toward a target, at one of two speeds picked by a rate input.

The target of a channel is its programmed code. It is zero while soft mute is asserted or while power-enable is low, so muting, un-muting, powering up and powering down all fade. A link input makes the left code the target of both channels. A mono input sends the average of the two scaled channels to both outputs. Each 12 codes of attenuation are applied as a one-bit arithmetic shift (about 6 dB). The remaining 0 to 11 half-decibel steps are applied by a 12-entry gain table, followed by rounding and saturation to 24 bits.

Top module: `soft_volume_ramp`

## Requirements
- R1: After reset both levels are 0, both sample outputs are 0 and `out_valid` is 0.
- R2: For a level L above 0, let a = 255 - L, k = a / 12 and f = a mod 12. The output is floor((s * G(f) + 2^(14+k)) / 2^(15+k)), where G(f) = round(32768 * 10^(-f/40)), s is the input sample and the result is saturated to 24 bits. A level of 0 gives exactly 0.
- R3: On each strobe, a channel whose level differs from its target increments its step count. When the count was already at N-1 or above, the level instead moves one code toward the target and the count restarts at 0. N is 4 with `rate_sel`=0 and 29 with `rate_sel`=1. A channel whose level equals its target clears its count.
- R4: The sample outputs update one clock after a strobe. They use the level held before that strobe's ramp update, and `out_valid` is high for exactly that clock.
- R5: With `link_ctl`=1 the target of the right channel is `code_left`. With `link_ctl`=0 it is `code_right`.
- R6: With `soft_mute`=1 both targets are 0. When `soft_mute` drops, the levels ramp back to their programmed codes at the selected rate.
- R7: Releasing soft mute in the middle of a ramp reverses the direction at the next step. The step count is not restarted.
- R8: With `power_en`=0 both targets are 0. When `power_en` returns to 1, the levels fade up to their codes.
- R9: With `mono_mix`=1 both outputs equal floor((VL + VR) / 2), where VL and VR are the scaled channel values.
- R10: Without a strobe, the levels and the sample outputs hold and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe, one per sample period |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| code_left | input | 8 | Left volume code (255 = 0 dB, 0 = mute) |
| code_right | input | 8 | Right volume code |
| link_ctl | input | 1 | Left code drives both channels |
| soft_mute | input | 1 | Fade both channels to silence |
| rate_sel | input | 1 | Ramp speed: 0 = 4 strobes per code, 1 = 29 |
| power_en | input | 1 | Low forces both targets to mute |
| mono_mix | input | 1 | Output the average of the two scaled channels |
| out_valid | output | 1 | Outputs updated this cycle |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| level_left | output | 8 | Current ramped left level |
| level_right | output | 8 | Current ramped right level |

## Verification
Two events can land on the same strobe: the release of soft mute, and the step count of a downward ramp reaching its limit. The bench stops a mute fade two strobes into a step interval and releases it there. It then checks that the very next step already goes upward, with no fresh wait of a full interval. The bench also runs a complete fade from mute to 0 dB, so the scaled output is compared against the decibel formula at every one of the 256 levels. A link toggle, a power drop and mono mixing are each applied while a ramp is still in progress.

// File: rtl/soft_volume_ramp.sv
module soft_volume_ramp #(
  parameter int DW        = 24,
  parameter int CW        = 8,
  parameter int GW        = 16,
  parameter int FAST_STEP = 4,
  parameter int SLOW_STEP = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic [CW-1:0]        code_left,
  input  logic [CW-1:0]        code_right,
  input  logic                 link_ctl,
  input  logic                 soft_mute,
  input  logic                 rate_sel,
  input  logic                 power_en,
  input  logic                 mono_mix,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic [CW-1:0]        level_left,
  output logic [CW-1:0]        level_right
);

  localparam int CNTW   = $clog2(SLOW_STEP + 1);
  localparam int PW     = DW + GW + 2;
  localparam int FSTEPS = 12;
  localparam logic [CW-1:0] FULL = '1;
  localparam logic signed [PW-1:0] SMAX = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] SMIN = -(PW'(1) <<< (DW - 1));

  function automatic logic [GW-1:0] frac_gain(input logic [3:0] f);
    case (f)
      4'd0:    return GW'(32768);
      4'd1:    return GW'(30935);
      4'd2:    return GW'(29205);
      4'd3:    return GW'(27571);
      4'd4:    return GW'(26029);
      4'd5:    return GW'(24573);
      4'd6:    return GW'(23198);
      4'd7:    return GW'(21900);
      4'd8:    return GW'(20675);
      4'd9:    return GW'(19519);
      4'd10:   return GW'(18427);
      default: return GW'(17396);
    endcase
  endfunction

  function automatic logic signed [DW-1:0] apply_gain(input logic signed [DW-1:0] s,
                                                      input logic [CW-1:0] lv);
    logic [CW-1:0] atten;
    int k, sh;
    logic signed [PW-1:0] prod, rnd;
    atten = FULL - lv;
    k     = int'(atten) / FSTEPS;
    sh    = GW - 1 + k;
    prod  = PW'(s) * $signed({2'b00, frac_gain(4'(int'(atten) % FSTEPS))});
    rnd   = (prod + (PW'(1) <<< (sh - 1))) >>> sh;
    if (lv == '0) return '0;
    if (rnd > SMAX) return SMAX[DW-1:0];
    if (rnd < SMIN) return SMIN[DW-1:0];
    return rnd[DW-1:0];
  endfunction

  logic [CW-1:0]        lvl [2];
  logic [CNTW-1:0]      cnt [2];
  logic [CW-1:0]        tgt [2];
  logic signed [DW-1:0] vol [2];
  logic [DW:0]          mix_sum;
  logic [CNTW-1:0]      step_lim;
  logic                 quiet;

  assign quiet    = soft_mute || !power_en;
  assign step_lim = rate_sel ? CNTW'(SLOW_STEP - 1) : CNTW'(FAST_STEP - 1);
  assign tgt[0]   = quiet ? '0 : code_left;
  assign tgt[1]   = quiet ? '0 : (link_ctl ? code_left : code_right);
  assign vol[0]   = apply_gain(in_left, lvl[0]);
  assign vol[1]   = apply_gain(in_right, lvl[1]);
  assign mix_sum  = {vol[0][DW-1], vol[0]} + {vol[1][DW-1], vol[1]};
  assign level_left  = lvl[0];
  assign level_right = lvl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      for (int c = 0; c < 2; c++) begin
        lvl[c] <= '0;
        cnt[c] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= mono_mix ? $signed(mix_sum[DW:1]) : vol[0];
        out_right <= mono_mix ? $signed(mix_sum[DW:1]) : vol[1];
        for (int c = 0; c < 2; c++) begin
          if (lvl[c] == tgt[c]) begin
            cnt[c] <= '0;
          end else if (cnt[c] >= step_lim) begin
            cnt[c] <= '0;
            lvl[c] <= (lvl[c] > tgt[c]) ? lvl[c] - 1'b1 : lvl[c] + 1'b1;
          end else begin
            cnt[c] <= cnt[c] + 1'b1;
          end
        end
      end
    end
  end

  assert_one_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_left) |-> (level_left == $past(level_left) + 1'b1 ||
                              level_left == $past(level_left) - 1'b1));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(level_left) && $stable(level_right) &&
                   $stable(out_left) && !out_valid));

  assert_strobe_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_mute_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mono_mix && level_left == '0) |=> out_left == '0);

  assert_mono_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mono_mix) |=> out_left == out_right);

  assert_power_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_en && level_right == '0) |=> level_right == '0);

endmodule

// File: tb/sim_soft_volume_ramp.sv
module sim_soft_volume_ramp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic [7:0] code_l = 8'h00, code_r = 8'h00;
  logic link = 1'b0, smute = 1'b0, rate = 1'b0, pwr = 1'b0, mono = 1'b0;
  logic out_valid;
  logic signed [23:0] out_l, out_r;
  logic [7:0] lev_l, lev_r;

  int checks = 0, errors = 0;
  int mlev [2];
  int mcnt [2];
  int unsigned seed = 32'h1234_5678;
  int scount = 0;

  always #2.5 clk = ~clk;

  soft_volume_ramp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_left(in_l), .in_right(in_r),
    .code_left(code_l), .code_right(code_r), .link_ctl(link), .soft_mute(smute),
    .rate_sel(rate), .power_en(pwr), .mono_mix(mono), .out_valid(out_valid),
    .out_left(out_l), .out_right(out_r), .level_left(lev_l), .level_right(lev_r));

  function automatic longint gain_of(int f);
    real v;
    v = 32768.0 * (10.0 ** (-f / 40.0));
    return longint'($rtoi(v + 0.5));
  endfunction

  function automatic longint exp_vol(longint s, int lv);
    int a, k, f, sh;
    longint p, r;
    if (lv == 0) return 0;
    a = 255 - lv; k = a / 12; f = a % 12; sh = 15 + k;
    p = s * gain_of(f);
    r = (p + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic gen(output logic signed [23:0] s);
    seed = seed * 32'd1664525 + 32'd1013904223;
    scount++;
    if (scount % 7 == 0)      s = 24'sh7FFFFF;
    else if (scount % 7 == 3) s = 24'sh800000;
    else                      s = seed[31:8];
  endtask

  task automatic strobe(input logic signed [23:0] l, input logic signed [23:0] r, input string tag);
    longint e0, e1, m;
    int lim;
    int mt [2];
    e0 = exp_vol(longint'(l), mlev[0]);
    e1 = exp_vol(longint'(r), mlev[1]);
    if (mono) begin m = (e0 + e1) >>> 1; e0 = m; e1 = m; end
    lim = rate ? 29 : 4;
    mt[0] = (smute || !pwr) ? 0 : int'(code_l);
    mt[1] = (smute || !pwr) ? 0 : (link ? int'(code_l) : int'(code_r));
    for (int c = 0; c < 2; c++) begin
      if (mlev[c] == mt[c]) mcnt[c] = 0;
      else if (mcnt[c] >= lim - 1) begin
        mcnt[c] = 0;
        mlev[c] = mlev[c] + ((mlev[c] > mt[c]) ? -1 : 1);
      end else mcnt[c] = mcnt[c] + 1;
    end
    in_l = l; in_r = r; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk(tag, "out_valid R4", longint'(out_valid), 1);
    chk(tag, "out_left", longint'(out_l), e0);
    chk(tag, "out_right", longint'(out_r), e1);
    chk(tag, "level_left", longint'(lev_l), longint'(mlev[0]));
    chk(tag, "level_right", longint'(lev_r), longint'(mlev[1]));
  endtask

  task automatic run(input int n, input string tag);
    logic signed [23:0] a, b;
    for (int i = 0; i < n; i++) begin
      gen(a); gen(b);
      strobe(a, b, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mlev[0] = 0; mlev[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
    code_l = 8'hFF; code_r = 8'hFF; pwr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "out_left", longint'(out_l), 0);
    chk("R1", "level_left", longint'(lev_l), 0);
    chk("R1", "level_right", longint'(lev_r), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1040, "R2 R3 fade-up sweep");
    chk("R3", "full level", longint'(lev_l), 255);

    code_l = 8'hFE;
    run(3, "R3 fast wait");
    chk("R3", "fast before step", longint'(lev_l), 255);
    run(1, "R3 fast step");
    chk("R3", "fast step", longint'(lev_l), 254);

    rate = 1'b1; code_l = 8'hF0;
    run(28, "R3 slow wait");
    chk("R3", "slow before step", longint'(lev_l), 254);
    run(1, "R3 slow step");
    chk("R3", "slow step", longint'(lev_l), 253);
    run(400, "R3 slow ramp");
    chk("R3", "slow target", longint'(lev_l), 240);

    rate = 1'b0; link = 1'b1; code_r = 8'h80;
    run(80, "R5 linked");
    chk("R5", "right follows left code", longint'(lev_r), 240);
    link = 1'b0;
    run(470, "R5 unlinked");
    chk("R5", "right own code", longint'(lev_r), 128);

    smute = 1'b1;
    run(22, "R6 mute fade");
    chk("R6", "mid fade", longint'(lev_l), 235);
    smute = 1'b0;
    run(2, "R7 reversal");
    chk("R7", "reversed at once", longint'(lev_l), 236);
    run(30, "R6 recover");
    chk("R6", "back to code", longint'(lev_l), 240);
    smute = 1'b1;
    run(1000, "R6 full mute");
    chk("R6", "muted left", longint'(lev_l), 0);
    chk("R6", "muted out", longint'(out_l), 0);
    smute = 1'b0;
    run(1000, "R6 unmute");
    chk("R6", "restored", longint'(lev_l), 240);

    pwr = 1'b0;
    run(1100, "R8 power down");
    chk("R8", "left forced mute", longint'(lev_l), 0);
    chk("R8", "right forced mute", longint'(lev_r), 0);
    pwr = 1'b1;
    run(1100, "R8 power up");
    chk("R8", "right faded up", longint'(lev_r), 128);

    mono = 1'b1; code_r = 8'h20;
    run(300, "R9 mono during ramp");
    chk("R9", "outputs equal", longint'(out_l), longint'(out_r));
    mono = 1'b0;

    begin
      logic signed [23:0] hl, hr;
      logic [7:0] hv;
      hl = out_l; hr = out_r; hv = lev_l;
      in_l = 24'sh123456; code_l = 8'h10; smute = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10", "valid low", longint'(out_valid), 0);
      chk("R10", "out_left held", longint'(out_l), longint'(hl));
      chk("R10", "out_right held", longint'(out_r), longint'(hr));
      chk("R10", "level held", longint'(lev_l), longint'(hv));
      smute = 1'b0; code_l = 8'hF0;
    end
    run(20, "R2 resume");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule